// File: doc/BRIEF.md
# Four-Channel Timer Input Capture

A free-running up-counter is shared by four capture channels. Each channel watches one external input, passes it through a two-flop synchronizer and tracks its last sampled level in a two-state machine (`LVL_LOW`, `LVL_HIGH`). The `rise` transition (`LVL_LOW` to `LVL_HIGH`) fires when the sampled level goes from 0 to 1. The `fall` transition (`LVL_HIGH` to `LVL_LOW`) fires when it goes from 1 to 0. When a transition fires and the matching enable is set, the channel copies the counter into its own capture register. If that channel's interrupt enable is also set, the load sets a sticky interrupt flag.

Software uses a small register port with a write strobe, an address, write data and combinational read data. Through it, software sets the per-channel configuration, starts and stops the counter, preloads the counter, reads the captures and clears flags by writing 1. The single interrupt output is high while any flag is set. Typical uses are pulse-width and period measurement: enable both edges on one channel, then subtract successive captures.

Top module: `tcap_unit`

## Requirements
- R1: After reset the configuration, run bit, counter, flags and all captures read 0, and `irq` is 0.
- R2: The counter register lives at address 2. While the run bit (address 1, bit 0) is 1, the counter adds 1 each clock and wraps from 0xFFFFFFFF to 0. While the run bit is 0, the counter holds. A write to address 2 loads the counter.
- R3: With a channel's rising enable set, a 0-to-1 change on its pin loads the capture register. The loaded value equals the counter value read in the cycle the pin changed, plus 2.
- R4: With a channel's falling enable set, a 1-to-0 change on its pin loads the capture register in the same way, also with the counter value plus 2.
- R5: With both enables set, a channel captures on every change of its pin.
- R6: A pin change whose direction is not enabled on that channel leaves its capture register unchanged.
- R7: A flag is set only by a capture load on a channel whose interrupt enable is set. An edge with no load, or a load with the interrupt enable clear, sets no flag.
- R8: The flag register is at address 3, bit i for channel i. Writing 1 to a bit clears it, and writing 0 has no effect. `irq` is the OR of the four flags.
- R9: When a flag clear and a flag-setting capture on the same channel fall in the same cycle, the flag ends set.
- R10: The configuration register is at address 0 and is 12 bits wide. Channel i uses bit 3i for rising enable, bit 3i+1 for falling enable and bit 3i+2 for interrupt enable. Bits above 11 read as 0.
- R11: Capture i reads at address 4+i. These registers are read-only, and writes to them are ignored.
- R12: A new capture overwrites the previous value of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_pin | input | 4 | External capture inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Register write data |
| rd_data | output | 32 | Register read data for `addr`, combinational |
| irq | output | 1 | High while any interrupt flag is set |

## Verification
A software clear of a flag and a capture that sets the same flag can land in the same cycle. To provoke this, the bench first leaves a flag set by an earlier capture. It then raises that channel's pin and issues the write-1-to-clear so that the write strobe is present on the exact edge where the capture loads, two clocks after the pin change. The flag is judged set afterward and the capture is judged updated. A plain clear with no capture in flight then checks that the flag does drop and `irq` falls.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    localparam int CFG_BITS = 3;
    localparam int RE_OFS   = 0;
    localparam int FE_OFS   = 1;
    localparam int IE_OFS   = 2;

    localparam int ADR_CFG   = 0;
    localparam int ADR_RUN   = 1;
    localparam int ADR_COUNT = 2;
    localparam int ADR_FLAG  = 3;
    localparam int ADR_CAP0  = 4;
endpackage

// File: rtl/tcap_edge.sv
module tcap_edge
    import tcap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [1:0] sync_q;
    logic       sampled;
    lvl_e       state_q, state_d;

    assign sampled = sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (sampled)  state_d = LVL_HIGH;
            LVL_HIGH: if (!sampled) state_d = LVL_LOW;
        endcase
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise = sampled;
            LVL_HIGH: fall = !sampled;
        endcase
    end

    // R3 / R4: an edge is reported once, then the tracked level follows the pin
    p_edge_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
    p_rise_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    p_fall_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/tcap_counter.sv
module tcap_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (load) count <= load_val;
        else if (run)  count <= count + 1'b1;
    end

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (count == $past(count) + 1'b1));
    p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));
    p_count_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/tcap_chan.sv
module tcap_chan #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  logic          re_en,
    input  logic          fe_en,
    input  logic          ie_en,
    input  logic [CW-1:0] count,
    input  logic          clr,
    output logic [CW-1:0] cap,
    output logic          flag
);
    logic rise, fall, load;

    tcap_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin),
        .rise (rise),
        .fall (fall)
    );

    assign load = (rise && re_en) || (fall && fe_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cap <= '0;
        else if (load) cap <= count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= (flag && !clr) || (load && ie_en);
    end

    p_cap_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cap == $past(count)));
    p_cap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cap));
    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ie_en) |=> flag);
    p_flag_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(load && ie_en)) |=> !flag);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ie_en && clr) |=> flag);
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> !flag);
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 32,
    parameter int AW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cap_pin,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [CW-1:0]  wdata,
    output logic [CW-1:0]  rd_data,
    output logic           irq
);
    localparam int CFG_W = CFG_BITS * NCH;

    logic [CFG_W-1:0] cfg_q;
    logic             run_q;
    logic [CW-1:0]    count;
    logic [NCH-1:0]   flag_vec;
    logic [NCH-1:0]   clr_vec;
    logic [CW-1:0]    cap_q [NCH];
    logic             wr_cfg, wr_run, wr_count, wr_flag;

    assign wr_cfg   = wr_en && (addr == AW'(ADR_CFG));
    assign wr_run   = wr_en && (addr == AW'(ADR_RUN));
    assign wr_count = wr_en && (addr == AW'(ADR_COUNT));
    assign wr_flag  = wr_en && (addr == AW'(ADR_FLAG));
    assign clr_vec  = wr_flag ? wdata[NCH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            run_q <= 1'b0;
        end else begin
            if (wr_cfg) cfg_q <= wdata[CFG_W-1:0];
            if (wr_run) run_q <= wdata[0];
        end
    end

    tcap_counter #(.CW(CW)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .load    (wr_count),
        .load_val(wdata),
        .count   (count)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tcap_chan #(.CW(CW)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (cap_pin[i]),
            .re_en(cfg_q[CFG_BITS*i + RE_OFS]),
            .fe_en(cfg_q[CFG_BITS*i + FE_OFS]),
            .ie_en(cfg_q[CFG_BITS*i + IE_OFS]),
            .count(count),
            .clr  (clr_vec[i]),
            .cap  (cap_q[i]),
            .flag (flag_vec[i])
        );
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            AW'(ADR_CFG):   rd_data = CW'(cfg_q);
            AW'(ADR_RUN):   rd_data = CW'(run_q);
            AW'(ADR_COUNT): rd_data = count;
            AW'(ADR_FLAG):  rd_data = CW'(flag_vec);
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (addr == AW'(ADR_CAP0 + i)) rd_data = cap_q[i];
                end
            end
        endcase
    end

    assign irq = |flag_vec;

    // R10: a configuration write is what the register holds afterwards
    p_cfg_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> (cfg_q == $past(wdata[CFG_W-1:0])));
    // R8: irq can only rise through a flag that was not set before
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(flag_vec) == '0));
endmodule

// File: tb/tcap_unit_tb.sv
module tcap_unit_tb;
    localparam int NCH = 4;
    localparam logic [2:0] A_CFG = 3'd0, A_RUN = 3'd1, A_CNT = 3'd2, A_FLAG = 3'd3, A_CAP0 = 3'd4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] cap_pin = '0;
    logic           wr_en = 1'b0;
    logic [2:0]     addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rd_data;
    logic           irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tcap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq)
    );

    // {ch[1:0], cfg {ie,fe,re}[2:0], rising, expect_load, expect_flag}
    localparam logic [7:0] VEC [12] = '{
        {2'd0, 3'b001, 1'b1, 1'b1, 1'b0},
        {2'd0, 3'b001, 1'b0, 1'b0, 1'b0},
        {2'd1, 3'b010, 1'b0, 1'b1, 1'b0},
        {2'd1, 3'b010, 1'b1, 1'b0, 1'b0},
        {2'd2, 3'b111, 1'b1, 1'b1, 1'b1},
        {2'd2, 3'b111, 1'b0, 1'b1, 1'b1},
        {2'd3, 3'b100, 1'b1, 1'b0, 1'b0},
        {2'd3, 3'b101, 1'b1, 1'b1, 1'b1},
        {2'd3, 3'b110, 1'b1, 1'b0, 1'b0},
        {2'd1, 3'b000, 1'b0, 1'b0, 1'b0},
        {2'd0, 3'b110, 1'b0, 1'b1, 1'b1},
        {2'd2, 3'b001, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    // drive a pin change and return the counter value seen in that cycle;
    // returns at the negedge after the capture edge
    task automatic pin_edge(input int ch, input logic val, output logic [31:0] c0);
        @(negedge clk);
        rd(A_CNT, c0);
        cap_pin[ch] = val;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, prev, c0, c1, first;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check(v == 0, "R1 reset register", v, 0);
        end
        check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);

        // R2 counter holds while stopped, runs, wraps, stops
        repeat (3) @(negedge clk);
        rd(A_CNT, v);
        check(v == 0, "R2 counter held while stopped", v, 0);
        wr(A_RUN, 1);
        rd(A_CNT, c0);
        @(negedge clk);
        rd(A_CNT, v);
        check(v == c0 + 1, "R2 counter step", v, c0 + 1);
        wr(A_CNT, 32'hFFFF_FFFE);
        rd(A_CNT, v);
        check(v == 32'hFFFF_FFFE, "R2 counter load", v, 32'hFFFF_FFFE);
        @(negedge clk);
        rd(A_CNT, v);
        check(v == 32'hFFFF_FFFF, "R2 counter before wrap", v, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(A_CNT, v);
        check(v == 0, "R2 counter wrap", v, 0);
        wr(A_RUN, 0);
        rd(A_CNT, c0);
        repeat (3) @(negedge clk);
        rd(A_CNT, v);
        check(v == c0, "R2 counter stopped", v, c0);
        wr(A_CNT, 32'h0000_1000);
        wr(A_RUN, 1);

        // R10 width and R11 read-only captures
        wr(A_CFG, 32'hFFFF_FFFF);
        rd(A_CFG, v);
        check(v == 32'h0000_0FFF, "R10 config readback", v, 32'h0000_0FFF);
        wr(A_CFG, 0);
        wr(A_CAP0 + 3'd1, 32'h1234_5678);
        rd(A_CAP0 + 3'd1, v);
        check(v == 0, "R11 capture write ignored", v, 0);

        // table walk: R3 R4 R5 R6 R7 R10
        for (int k = 0; k < 12; k++) begin
            int ch;
            logic [2:0] cfg;
            logic dir, eload, eflag;
            string tag;
            ch = int'(VEC[k][7:6]);
            cfg = VEC[k][5:3];
            dir = VEC[k][2];
            eload = VEC[k][1];
            eflag = VEC[k][0];
            if (!eload) tag = "R6";
            else if (cfg[1:0] == 2'b11) tag = "R5";
            else if (dir) tag = "R3";
            else tag = "R4";
            wr(A_CFG, 0);
            cap_pin[ch] = !dir;
            repeat (4) @(negedge clk);
            wr(A_CFG, 32'(cfg) << (3 * ch));
            wr(A_FLAG, 32'hF);
            rd(A_CAP0 + 3'(ch), prev);
            pin_edge(ch, dir, c0);
            rd(A_CAP0 + 3'(ch), v);
            c1 = eload ? c0 + 2 : prev;
            check(v == c1, $sformatf("%s R10 vector %0d capture", tag, k), v, c1);
            rd(A_FLAG, v);
            check(v == (32'(eflag) << ch), $sformatf("R7 vector %0d flag", k), v, 32'(eflag) << ch);
            check(irq == eflag, $sformatf("R8 vector %0d irq", k), 32'(irq), 32'(eflag));
        end

        // R12 overwrite on channel 0 (pin 0 is low here)
        wr(A_CFG, 32'b001);
        pin_edge(0, 1'b1, c0);
        rd(A_CAP0, first);
        check(first == c0 + 2, "R12 first capture", first, c0 + 2);
        cap_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        pin_edge(0, 1'b1, c1);
        rd(A_CAP0, v);
        check(v == c1 + 2 && v != first, "R12 overwrite capture", v, c1 + 2);

        // R9 set wins over same-cycle clear
        cap_pin[0] = 1'b0;
        wr(A_CFG, 32'b101);
        wr(A_FLAG, 32'hF);
        repeat (3) @(negedge clk);
        pin_edge(0, 1'b1, c0);
        rd(A_FLAG, v);
        check(v == 1, "R7 flag set by capture", v, 1);
        cap_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        @(negedge clk);
        rd(A_CNT, c0);
        cap_pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = A_FLAG; wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(A_FLAG, v);
        check(v == 1, "R9 set wins over clear", v, 1);
        rd(A_CAP0, v);
        check(v == c0 + 2, "R9 capture during clear", v, c0 + 2);

        // R8 write 0 no effect, write 1 clears
        wr(A_FLAG, 0);
        rd(A_FLAG, v);
        check(v == 1, "R8 write zero keeps flag", v, 1);
        check(irq == 1'b1, "R8 irq while flag set", 32'(irq), 1);
        wr(A_FLAG, 1);
        rd(A_FLAG, v);
        check(v == 0, "R8 write one clears flag", v, 0);
        check(irq == 1'b0, "R8 irq after clear", 32'(irq), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule